// File: doc/BRIEF.md
# Audio Frame Sequencer with Reset Replay

The block paces the slow housekeeping of an audio unit. It runs on the CPU-rate clock and counts cycles through one of two step patterns. On each step it emits a one-cycle quarter-frame pulse, and on some steps it also emits a half-frame pulse. In the four-step pattern it also raises a level-sensitive frame interrupt request. Software programs the block through a single control-register write port. A status-read strobe acknowledges the interrupt.

The block has two reset inputs. Power-up forgets everything, while a warm reset keeps the last control value software wrote. In both cases the block waits a fixed number of cycles after the reset and then applies an internal control write. That write carries zero after power-up and the remembered value after a warm reset. The sequence therefore restarts in the mode and inhibit setting software last chose, and any pending interrupt is dropped.

Top module: `frameSequencer`

## Requirements
- R1: A power-up reset sets the remembered control value to 0x00. The internal rewrite takes effect on the 10th clock edge after the last edge that sampled the power-up input. The first quarter pulse then appears 7457 cycles after that rewrite.
- R2: A warm reset keeps the remembered control value and replays it as an internal write on the 10th clock edge after the last edge that sampled the warm reset. The replay behaves exactly like a software write of that value.
- R3: Both resets clear a pending frame interrupt. While a reset is held and until the rewrite, no tick pulses appear.
- R4: Four-step mode (control bit 7 = 0). Counting from the write edge, where the cycle after it is count 0, quarter pulses occur at counts 7457, 14913, 22371 and 29829. Half pulses occur at 14913 and 29829. The count wraps to 0 after 29829.
- R5: Five-step mode (control bit 7 = 1). Quarter pulses occur at counts 7457, 14913, 22371 and 37281, and half pulses at 14913 and 37281. There is no pulse at 29829, and the count wraps to 0 after 37281.
- R6: In four-step mode with control bit 6 = 0, the interrupt rises in the cycle after the count-29829 step and stays high until it is cleared. Five-step mode never raises it.
- R7: A status-read strobe clears the interrupt. If the strobe falls on the same edge as the interrupt-setting step, the interrupt is set.
- R8: A control write with bit 6 = 1 clears the interrupt and inhibits further setting. A write with bit 6 = 0 leaves a pending interrupt high.
- R9: A control write with bit 7 = 1, whether from software or from the reset replay, gives a quarter and a half pulse together in the cycle right after the write edge.
- R10: Every control write restarts the count at 0 in the cycle after the write edge. Software writes update the remembered value, and the other control bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| pwrUpRst | input | 1 | Synchronous power-up reset, active high |
| warmRst | input | 1 | Synchronous warm reset, active high |
| ctrlWr | input | 1 | Control-register write strobe |
| ctrlData | input | 8 | Control value: bit 7 mode, bit 6 interrupt inhibit |
| statusRd | input | 1 | Status-read strobe, acknowledges the interrupt |
| quarterTick | output | 1 | One-cycle quarter-frame pulse |
| halfTick | output | 1 | One-cycle half-frame pulse |
| frameIrq | output | 1 | Frame interrupt request, level |

## Verification
The status-read acknowledge and the four-step interrupt-setting step can land on the same clock edge, and they pull the flag in opposite directions. A directed case counts 29829 cycles from a write of 0x00 and raises the read strobe exactly on that edge. The flag must then still be high in the following cycle, and a later read must drop it. Randomly timed reads, writes and warm resets against a cycle-accurate bench model also hit this pairing and the pairing of a write with a sequencer step.

// File: rtl/frameSeqPkg.sv
package frameSeqPkg;
  localparam int MODE_BIT = 7;
  localparam int INH_BIT  = 6;

  typedef struct packed {
    logic wipe;        // any reset this cycle
    logic restart;     // a control write takes effect this edge
    logic run;         // sequencer counting
    logic mode5;       // current mode: five-step
    logic nextMode5;   // mode carried by the write this edge
    logic inhibit;     // current interrupt inhibit
    logic inhibitLoad; // write this edge sets inhibit
    logic ack;         // status read this edge
  } seqStrobe_t;
endpackage

// File: rtl/frameCtrl.sv
module frameCtrl
  import frameSeqPkg::*;
#(
  parameter int REPLAY_DELAY = 10
) (
  input  logic       clk,
  input  logic       pwrUpRst,
  input  logic       warmRst,
  input  logic       ctrlWr,
  input  logic [7:0] ctrlData,
  input  logic       statusRd,
  output seqStrobe_t strb
);
  localparam int DLY_W = $clog2(REPLAY_DELAY + 1);

  logic [7:0]       lastCtrl;
  logic             modeQ, inhQ, runQ;
  logic [DLY_W-1:0] delayQ;
  logic             anyRst, replayNow, doWrite;
  logic [7:0]       wrVal;

  assign anyRst    = pwrUpRst || warmRst;
  assign replayNow = !anyRst && (delayQ == DLY_W'(1));
  assign doWrite   = !anyRst && (ctrlWr || replayNow);
  assign wrVal     = ctrlWr ? ctrlData : lastCtrl;

  always_ff @(posedge clk) begin
    if (pwrUpRst) begin
      lastCtrl <= 8'h00;
      modeQ    <= 1'b0;
      inhQ     <= 1'b0;
      runQ     <= 1'b0;
      delayQ   <= DLY_W'(REPLAY_DELAY);
    end else if (warmRst) begin
      runQ     <= 1'b0;
      delayQ   <= DLY_W'(REPLAY_DELAY);
    end else begin
      if (ctrlWr) lastCtrl <= ctrlData;
      if (doWrite) begin
        modeQ <= wrVal[MODE_BIT];
        inhQ  <= wrVal[INH_BIT];
        runQ  <= 1'b1;
      end
      if (delayQ != '0) delayQ <= delayQ - 1'b1;
    end
  end

  always_comb begin
    strb.wipe        = anyRst;
    strb.restart     = doWrite;
    strb.run         = runQ;
    strb.mode5       = modeQ;
    strb.nextMode5   = wrVal[MODE_BIT];
    strb.inhibit     = inhQ;
    strb.inhibitLoad = doWrite && wrVal[INH_BIT];
    strb.ack         = statusRd;
  end

  // R1: power-up forgets the remembered control value
  p_power_forgets_r1: assert property (@(posedge clk)
    pwrUpRst |=> (lastCtrl == 8'h00));

  // R2: the replay countdown ends with the sequencer running
  p_replay_starts_r2: assert property (@(posedge clk) disable iff (pwrUpRst)
    (!warmRst && delayQ == DLY_W'(1)) |=> runQ);

  // R2: warm reset keeps the remembered value
  p_warm_keeps_r2: assert property (@(posedge clk) disable iff (pwrUpRst)
    (warmRst && !ctrlWr) |=> $stable(lastCtrl));
endmodule

// File: rtl/frameData.sv
module frameData
  import frameSeqPkg::*;
#(
  parameter int STEP1 = 7457,
  parameter int STEP2 = 14913,
  parameter int STEP3 = 22371,
  parameter int LAST4 = 29829,
  parameter int LAST5 = 37281
) (
  input  logic       clk,
  input  seqStrobe_t strb,
  output logic       quarterTick,
  output logic       halfTick,
  output logic       frameIrq
);
  localparam int CNT_W = $clog2(LAST5 + 1);
  localparam int SHARED_STEPS [3] = '{STEP1, STEP2, STEP3};

  logic [CNT_W-1:0] cnt, lastStep;
  logic [2:0]       hitVec;
  logic             lastHit, setNow, immQ, irqQ;

  for (genvar g = 0; g < 3; g++) begin : g_shared
    assign hitVec[g] = (cnt == CNT_W'(SHARED_STEPS[g]));
  end

  assign lastStep = strb.mode5 ? CNT_W'(LAST5) : CNT_W'(LAST4);
  assign lastHit  = (cnt == lastStep);
  assign setNow   = strb.run && !strb.mode5 && lastHit && !strb.inhibit;

  always_ff @(posedge clk) begin
    if (strb.wipe) begin
      cnt  <= '0;
      immQ <= 1'b0;
      irqQ <= 1'b0;
    end else begin
      if (strb.restart)  cnt <= '0;
      else if (strb.run) cnt <= lastHit ? '0 : cnt + 1'b1;
      immQ <= strb.restart && strb.nextMode5;
      if (strb.inhibitLoad) irqQ <= 1'b0;
      else if (setNow)      irqQ <= 1'b1;
      else if (strb.ack)    irqQ <= 1'b0;
    end
  end

  assign quarterTick = immQ || (strb.run && (|hitVec || lastHit));
  assign halfTick    = immQ || (strb.run && (hitVec[1] || lastHit));
  assign frameIrq    = irqQ;

  // R4: a half pulse always comes with a quarter pulse
  p_half_with_quarter_r4: assert property (@(posedge clk) disable iff (strb.wipe)
    halfTick |-> quarterTick);

  // R6: five-step mode never raises the interrupt
  p_no_irq_five_r6: assert property (@(posedge clk) disable iff (strb.wipe)
    (strb.mode5 && !frameIrq) |=> !frameIrq);

  // R8: an inhibiting write drops the flag
  p_inhibit_clears_r8: assert property (@(posedge clk) disable iff (strb.wipe)
    strb.inhibitLoad |=> !frameIrq);

  // R9: a five-step write gives both pulses next cycle
  p_imm_tick_r9: assert property (@(posedge clk) disable iff (strb.wipe)
    (strb.restart && strb.nextMode5) |=> (quarterTick && halfTick));
endmodule

// File: rtl/frameSequencer.sv
module frameSequencer
  import frameSeqPkg::*;
#(
  parameter int STEP1        = 7457,
  parameter int STEP2        = 14913,
  parameter int STEP3        = 22371,
  parameter int LAST4        = 29829,
  parameter int LAST5        = 37281,
  parameter int REPLAY_DELAY = 10
) (
  input  logic       clk,
  input  logic       pwrUpRst,
  input  logic       warmRst,
  input  logic       ctrlWr,
  input  logic [7:0] ctrlData,
  input  logic       statusRd,
  output logic       quarterTick,
  output logic       halfTick,
  output logic       frameIrq
);
  seqStrobe_t strb;

  frameCtrl #(.REPLAY_DELAY(REPLAY_DELAY)) i_ctrl (
    .clk(clk), .pwrUpRst(pwrUpRst), .warmRst(warmRst),
    .ctrlWr(ctrlWr), .ctrlData(ctrlData), .statusRd(statusRd),
    .strb(strb)
  );

  frameData #(.STEP1(STEP1), .STEP2(STEP2), .STEP3(STEP3),
              .LAST4(LAST4), .LAST5(LAST5)) i_data (
    .clk(clk), .strb(strb),
    .quarterTick(quarterTick), .halfTick(halfTick), .frameIrq(frameIrq)
  );

  // R3: either reset leaves the interrupt low afterwards
  p_reset_drops_irq_r3: assert property (@(posedge clk) disable iff (pwrUpRst)
    warmRst |=> !frameIrq);
endmodule

// File: tb/test_frameSequencer.sv
`timescale 1ns/1ps
module test_frameSequencer;
  logic clk = 1'b0;
  logic pwrUpRst = 1'b1, warmRst = 1'b0, ctrlWr = 1'b0, statusRd = 1'b0;
  logic [7:0] ctrlData = 8'h00;
  logic quarterTick, halfTick, frameIrq;

  frameSequencer i_frameSequencer (
    .clk(clk), .pwrUpRst(pwrUpRst), .warmRst(warmRst), .ctrlWr(ctrlWr),
    .ctrlData(ctrlData), .statusRd(statusRd),
    .quarterTick(quarterTick), .halfTick(halfTick), .frameIrq(frameIrq)
  );

  always #2 clk = ~clk;

  int nChk = 0, nBad = 0, cyc = 0, mism = 0;
  int firstAct = 0, firstExp = 0;
  bit cmpOn = 0, done = 0;

  // reference model state, built from the requirements
  int mCnt = 0, mDelay = 0;
  bit mRun = 0, mMode5 = 0, mInh = 0, mFlag = 0, mImm = 0;
  logic [7:0] mLast = 8'h00;

  function automatic bit isQ(int c, bit m5);
    return c == 7457 || c == 14913 || c == 22371 || c == (m5 ? 37281 : 29829);
  endfunction
  function automatic bit isH(int c, bit m5);
    return c == 14913 || c == (m5 ? 37281 : 29829);
  endfunction

  always @(posedge clk) begin
    bit doW, setIt;
    logic [7:0] v;
    if (pwrUpRst) begin
      mLast = 8'h00; mMode5 = 0; mInh = 0; mFlag = 0;
      mRun = 0; mCnt = 0; mImm = 0; mDelay = 10;
    end else if (warmRst) begin
      mFlag = 0; mRun = 0; mCnt = 0; mImm = 0; mDelay = 10;
    end else begin
      doW   = ctrlWr || (mDelay == 1);
      v     = ctrlWr ? ctrlData : mLast;
      setIt = mRun && !mMode5 && (mCnt == 29829) && !mInh;
      if (doW && v[6])   mFlag = 0;
      else if (setIt)    mFlag = 1;
      else if (statusRd) mFlag = 0;
      if (doW)       mCnt = 0;
      else if (mRun) mCnt = (mCnt == (mMode5 ? 37281 : 29829)) ? 0 : mCnt + 1;
      mImm = doW && v[7];
      if (doW) begin mMode5 = v[7]; mInh = v[6]; mRun = 1; end
      if (ctrlWr) mLast = ctrlData;
      if (mDelay > 0) mDelay--;
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      logic [2:0] expV, actV;
      expV = {mImm || (mRun && isQ(mCnt, mMode5)),
              mImm || (mRun && isH(mCnt, mMode5)), mFlag};
      actV = {quarterTick, halfTick, frameIrq};
      if (expV !== actV) begin
        if (mism == 0) begin firstAct = int'(actV); firstExp = int'(expV); end
        mism++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic endPhase(input string tag);
    chk(mism == 0, tag, "model mismatch {q,h,irq} first", firstAct, firstExp);
    mism = 0;
  endtask

  task automatic outs(input string tag, input bit q, input bit h, input bit irq);
    chk(quarterTick == q, tag, "quarterTick", int'(quarterTick), int'(q));
    chk(halfTick == h, tag, "halfTick", int'(halfTick), int'(h));
    chk(frameIrq == irq, tag, "frameIrq", int'(frameIrq), int'(irq));
  endtask

  task automatic wr(input logic [7:0] v);
    ctrlData = v; ctrlWr = 1'b1;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic rd();
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !done) begin
      nBad++;
      $display("FAIL R10 watchdog: actual=%0d expected=%0d", cyc, 195000);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    outs("R3", 0, 0, 0);               // reset state
    pwrUpRst = 1'b0;
    cmpOn = 1;

    // R1 / R4 / R6: power-up rewrite of zero, four-step schedule
    repeat (10 + 7456) @(negedge clk);
    outs("R1", 0, 0, 0);
    @(negedge clk);
    outs("R1", 1, 0, 0);               // count 7457
    repeat (7456) @(negedge clk);
    outs("R4", 1, 1, 0);               // 14913
    repeat (7458) @(negedge clk);
    outs("R4", 1, 0, 0);               // 22371
    repeat (7458) @(negedge clk);
    outs("R4", 1, 1, 0);               // 29829
    @(negedge clk);
    outs("R6", 0, 0, 1);               // flag rises, count wraps
    rd();
    outs("R7", 0, 0, 0);
    endPhase("R4");

    // R7 / R8: read colliding with set, then write effects on the flag
    wr(8'h00);
    outs("R10", 0, 0, 0);              // no immediate tick in four-step
    repeat (29829) @(negedge clk);
    rd();                              // read on the setting edge
    outs("R7", 0, 0, 1);
    wr(8'h00);
    chk(frameIrq == 1'b1, "R8", "flag kept by bit6=0 write", int'(frameIrq), 1);
    wr(8'h40);
    chk(frameIrq == 1'b0, "R8", "flag cleared by bit6=1 write", int'(frameIrq), 0);
    endPhase("R7");

    // R9 / R2 / R5: five-step write, warm-reset replay, five-step schedule
    wr(8'hC0);
    outs("R9", 1, 1, 0);
    warmRst = 1'b1;
    @(negedge clk);
    warmRst = 1'b0;
    outs("R3", 0, 0, 0);
    repeat (9) @(negedge clk);
    outs("R2", 0, 0, 0);
    @(negedge clk);
    outs("R2", 1, 1, 0);               // replay of 0xC0 fires both pulses
    repeat (22371) @(negedge clk);
    outs("R5", 1, 0, 0);
    repeat (7458) @(negedge clk);
    outs("R5", 0, 0, 0);               // 29829: nothing in five-step
    repeat (7452) @(negedge clk);
    outs("R5", 1, 1, 0);               // 37281
    @(negedge clk);
    outs("R5", 0, 0, 0);
    endPhase("R5");

    // R10: random writes, reads and warm resets against the model
    for (int i = 0; i < 50000; i++) begin
      int r;
      r = $urandom;
      ctrlWr   = (r % 3000) == 0;
      ctrlData = {r[13:12], r[21:16]};
      statusRd = ($urandom % 400) == 0;
      warmRst  = ($urandom % 15000) == 0;
      @(negedge clk);
    end
    ctrlWr = 0; statusRd = 0; warmRst = 0;
    @(negedge clk);
    endPhase("R10");
    finishRun();
  end
endmodule